// File: doc/BRIEF.md
# System Interrupt Mapping Controller

This block sits between a set of peripheral interrupt request lines and the general-purpose levels of a core event controller. Each of the 24 sources has a 4-bit level field. The field routes the source to one of the general-purpose levels 7 to 15. All unmasked sources that share a level are OR-merged into a single request line. This means several simultaneous assertions reach the core as one request. Software reads a live status word to find which source is driving a shared level.

A per-source wakeup enable lets selected sources raise a wakeup request while the core is idle. This path does not depend on the mask. The block watches the core's pending-event bits for the general-purpose levels. When a level is accepted (its pending bit rises), the level output drops for exactly one cycle. If sources are still asserted, the line then rises again, so the core sees a fresh edge to queue. Registers are reached over a simple synchronous bus with word addresses and registered read data.

Top module: `sys_irq_router`

## Requirements
- R1: After reset the mask and wakeup-enable words are zero, all outputs are low, and the level fields hold 7,7,7,7,7,7,7,8,8,9,9,9,9,10,10,10,11,11,11,12,12,13,13,13 for sources 0 to 23. Source s sits in assignment word s/8 at bits 4*(s%8)+3 down to 4*(s%8), so the reset assignment words read 0x87777777, 0xAAA99998 and 0xDDDCCBBB.
- R2: Word addresses are 0 mask, 1 status, 2 wakeup enable, and 3/4/5 the assignment words. Bit s of mask, status and wakeup enable belongs to source s. Read data appears one clock after the address is presented. Bits 31..24 of the mask, status and wakeup-enable words read zero, other addresses read zero, and writes to the status word are ignored.
- R3: A source with its mask bit at 0 never contributes to any level output. A mask bit at 1 lets it through.
- R4: Status bit s reads 1 exactly when source s was high at the sampling edge, whatever the mask and enable settings are. It is not latched.
- R5: Level output bit L (7 to 15) goes high two clocks after any unmasked source whose field equals L goes high. Several sources on one level give one merged request.
- R6: A rewritten level field takes effect for the next routing decision. Field values 0 to 6 reach no output, and output bits 6..0 are always 0.
- R7: The wakeup output is high one clock after the core is idle while some source with its wakeup-enable bit set is high, independent of the mask. It is low otherwise.
- R8: A rising edge on pending bit i (level 7+i) forces level output 7+i low for exactly the next cycle. The output then follows its sources again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_src | input | 24 | Peripheral request lines, active high |
| core_idle | input | 1 | Core is idle |
| core_gp_pend | input | 9 | Pending bits of levels 7..15 (bit i = level 7+i) |
| irq_level | output | 16 | Request per level; bits 6..0 tied low |
| wake_req | output | 1 | Wakeup request |

## Verification
The bench checks merging by driving several sources that share a level. A design that routed per source, or ignored all but one, would leave a bit wrong in the level word. It remaps source 23 to level 15 and then to level 3: a stale field or a missing tie-off of the low levels would show a request on the wrong line. The bench drives a pending-bit rising edge while a level is held active. A design without the one-cycle gap, or with a gap that never closes, reads low or high in the wrong cycle. The bench also confirms that status ignores the mask, that wakeup ignores the mask but needs idle, and that status writes and upper bits leave no trace.

// File: rtl/sic_pkg.sv
// Shared constants for the system interrupt mapping controller.
// Assumes 32-bit register words and 4-bit level fields.
package sic_pkg;
    localparam int REG_W   = 32;
    localparam int LVL_W   = 4;
    localparam int GP_LO   = 7;
    localparam int GP_N    = 9;
    localparam int NUM_LVL = GP_LO + GP_N;
    localparam int ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] A_MASK = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_WAKE = 3'd2;
    localparam logic [ADDR_W-1:0] A_ASG0 = 3'd3;

    // Reset level for a source index, derived from run boundaries.
    function automatic logic [LVL_W-1:0] dflt_level(input int idx);
        if (idx < 7)       return 4'd7;
        else if (idx < 9)  return 4'd8;
        else if (idx < 13) return 4'd9;
        else if (idx < 16) return 4'd10;
        else if (idx < 19) return 4'd11;
        else if (idx < 21) return 4'd12;
        else               return 4'd13;
    endfunction
endpackage

// File: rtl/sic_regs.sv
// Register file: mask, wakeup enable and level fields, plus read mux.
// Assumes NUM_SRC <= 32; fields are packed eight per word.
module sic_regs
    import sic_pkg::*;
#(
    parameter int NUM_SRC = 24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_we,
    input  logic [REG_W-1:0]              bus_wdata,
    input  logic [NUM_SRC-1:0]            src_q,
    output logic [REG_W-1:0]              rd_data,
    output logic [NUM_SRC-1:0]            mask_q,
    output logic [NUM_SRC-1:0]            wake_en_q,
    output logic [NUM_SRC-1:0][LVL_W-1:0] sel_q
);
    localparam int PER_REG = REG_W / LVL_W;

    logic [REG_W-1:0] rd_nxt;

    // Update mask and wakeup-enable words on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q    <= '0;
            wake_en_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_MASK) mask_q    <= bus_wdata[NUM_SRC-1:0];
            if (bus_addr == A_WAKE) wake_en_q <= bus_wdata[NUM_SRC-1:0];
        end
    end

    // One level field per source, written from its assignment word.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_sel
        localparam int WRD = s / PER_REG;
        localparam int LSB = (s % PER_REG) * LVL_W;
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_q[s] <= dflt_level(s);
            else if (bus_we && (int'(bus_addr) == int'(A_ASG0) + WRD))
                sel_q[s] <= bus_wdata[LSB +: LVL_W];
        end
    end

    // Select the word addressed this cycle.
    always_comb begin
        rd_nxt = '0;
        case (bus_addr)
            A_MASK:  rd_nxt[NUM_SRC-1:0] = mask_q;
            A_STAT:  rd_nxt[NUM_SRC-1:0] = src_q;
            A_WAKE:  rd_nxt[NUM_SRC-1:0] = wake_en_q;
            default: begin
                for (int s = 0; s < NUM_SRC; s++)
                    if (int'(bus_addr) == int'(A_ASG0) + s / PER_REG)
                        rd_nxt[(s % PER_REG) * LVL_W +: LVL_W] = sel_q[s];
            end
        endcase
    end

    // Register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_nxt;
    end
endmodule

// File: rtl/sic_route.sv
// Per-level OR merge of unmasked sources, with a one-cycle re-arm gap
// when the core's pending bit for that level rises.
// Assumes field values below GP_LO or above 15 select no output.
module sic_route
    import sic_pkg::*;
#(
    parameter int NUM_SRC = 24
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            src_q,
    input  logic [NUM_SRC-1:0]            mask_q,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] sel_q,
    input  logic [GP_N-1:0]               gp_pend,
    output logic [NUM_LVL-1:0]            irq_level
);
    logic [GP_N-1:0] pend_d;
    logic [GP_N-1:0] hit;
    logic [GP_N-1:0] lvl_q;

    // Delay pending bits to find their rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_d <= '0;
        else        pend_d <= gp_pend;
    end

    for (genvar g = 0; g < GP_N; g++) begin : g_lvl
        // Merge every unmasked source whose field selects this level.
        always_comb begin
            hit[g] = 1'b0;
            for (int s = 0; s < NUM_SRC; s++)
                if (src_q[s] && mask_q[s] && (int'(sel_q[s]) == GP_LO + g))
                    hit[g] = 1'b1;
        end

        // Register the request, gapped on acceptance.
        always_ff @(posedge clk) begin
            if (!rst_n) lvl_q[g] <= 1'b0;
            else        lvl_q[g] <= hit[g] && !(gp_pend[g] && !pend_d[g]);
        end
    end

    assign irq_level = {lvl_q, {GP_LO{1'b0}}};
endmodule

// File: rtl/sic_wake.sv
// Wakeup request: an enabled asserting source while the core idles.
// Assumes the mask does not gate wakeup.
module sic_wake #(
    parameter int NUM_SRC = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_q,
    input  logic [NUM_SRC-1:0] wake_en_q,
    input  logic               core_idle,
    output logic               wake_req
);
    // Register the wakeup condition.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_req <= 1'b0;
        else        wake_req <= core_idle && (|(src_q & wake_en_q));
    end
endmodule

// File: rtl/sys_irq_router.sv
// Top of the system interrupt mapping controller. Samples the request
// lines once, then feeds registers, routing and wakeup logic.
// Assumes request lines are synchronous to clk.
module sys_irq_router
    import sic_pkg::*;
#(
    parameter int NUM_SRC = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_we,
    input  logic [REG_W-1:0]       bus_wdata,
    output logic [REG_W-1:0]       rd_data,
    input  logic [NUM_SRC-1:0]     irq_src,
    input  logic                   core_idle,
    input  logic [GP_N-1:0]        core_gp_pend,
    output logic [NUM_LVL-1:0]     irq_level,
    output logic                   wake_req
);
    logic [NUM_SRC-1:0]            src_q;
    logic [NUM_SRC-1:0]            mask_w;
    logic [NUM_SRC-1:0]            wake_en_w;
    logic [NUM_SRC-1:0][LVL_W-1:0] sel_w;

    // Sample the request lines.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= irq_src;
    end

    sic_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .src_q     (src_q),
        .rd_data   (rd_data),
        .mask_q    (mask_w),
        .wake_en_q (wake_en_w),
        .sel_q     (sel_w)
    );

    sic_route #(.NUM_SRC(NUM_SRC)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_q     (src_q),
        .mask_q    (mask_w),
        .sel_q     (sel_w),
        .gp_pend   (core_gp_pend),
        .irq_level (irq_level)
    );

    sic_wake #(.NUM_SRC(NUM_SRC)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_q     (src_q),
        .wake_en_q (wake_en_w),
        .core_idle (core_idle),
        .wake_req  (wake_req)
    );
endmodule

// File: rtl/sys_irq_router_chk.sv
// Temporal checks for the mapping controller, bound to its top.
module sys_irq_router_chk
    import sic_pkg::*;
#(
    parameter int NUM_SRC = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [REG_W-1:0]   rd_data,
    input logic [NUM_SRC-1:0] src_q,
    input logic [NUM_SRC-1:0] mask_w,
    input logic               core_idle,
    input logic [GP_N-1:0]    core_gp_pend,
    input logic [NUM_LVL-1:0] irq_level,
    input logic               wake_req
);
    // R6
    low_levels_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level[GP_LO-1:0] == '0);

    // R7
    wake_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(core_idle));

    // R3
    all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_w == '0) |=> (irq_level == '0));

    // R5
    level_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> $past(src_q != '0));

    // R2
    upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_addr) <= A_WAKE) |-> (rd_data[REG_W-1:NUM_SRC] == '0));

    for (genvar g = 0; g < GP_N; g++) begin : g_gap
        // R8
        rearm_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(core_gp_pend[g]) |=> !irq_level[GP_LO + g]);
    end
endmodule

bind sys_irq_router sys_irq_router_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .rd_data      (rd_data),
    .src_q        (src_q),
    .mask_w       (mask_w),
    .core_idle    (core_idle),
    .core_gp_pend (core_gp_pend),
    .irq_level    (irq_level),
    .wake_req     (wake_req)
);

// File: tb/sys_irq_router_test.sv
module sys_irq_router_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_data;
    logic [23:0] irq_src = '0;
    logic        core_idle = 1'b0;
    logic [8:0]  core_gp_pend = '0;
    logic [15:0] irq_level;
    logic        wake_req;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    sys_irq_router uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .rd_data(rd_data), .irq_src(irq_src),
        .core_idle(core_idle), .core_gp_pend(core_gp_pend),
        .irq_level(irq_level), .wake_req(wake_req)
    );

    // {source lines, mask, expected level word}, default level fields
    localparam logic [63:0] VEC [8] = '{
        {24'h000001, 24'hFFFFFF, 16'h0080},
        {24'h000180, 24'hFFFFFF, 16'h0100},
        {24'h00007F, 24'hFFFFFF, 16'h0080},
        {24'h800000, 24'h000000, 16'h0000},
        {24'h300000, 24'h200000, 16'h2000},
        {24'hFFFFFF, 24'hFFFFFF, 16'h3F80},
        {24'h002000, 24'h002000, 16'h0400},
        {24'h000000, 24'hFFFFFF, 16'h0000}
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic drive_src(input logic [23:0] s);
        @(negedge clk);
        irq_src = s;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog R1..all actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check({16'h0, irq_level}, 32'h0, "R1 level after reset");
        check({31'h0, wake_req}, 32'h0, "R1 wake after reset");
        rd(3'd0, d); check(d, 32'h0, "R1 mask reset");
        rd(3'd2, d); check(d, 32'h0, "R1 wake enable reset");
        rd(3'd3, d); check(d, 32'h87777777, "R1 assign word 0");
        rd(3'd4, d); check(d, 32'hAAA99998, "R1 assign word 1");
        rd(3'd5, d); check(d, 32'hDDDCCBBB, "R1 assign word 2");

        // R3 R4 R5 vector table
        for (int i = 0; i < 8; i++) begin
            wr(3'd0, {8'h0, VEC[i][39:16]});
            drive_src(VEC[i][63:40]);
            check({16'h0, irq_level}, {16'h0, VEC[i][15:0]}, $sformatf("R5 R3 vector %0d", i));
            rd(3'd1, d);
            check(d, {8'h0, VEC[i][63:40]}, $sformatf("R4 status vector %0d", i));
        end

        // R2 upper bits, status write ignored, unused address
        wr(3'd0, 32'hFFFFFFFF);
        rd(3'd0, d); check(d, 32'h00FFFFFF, "R2 mask upper bits");
        drive_src(24'h0);
        wr(3'd1, 32'hFFFFFFFF);
        rd(3'd1, d); check(d, 32'h0, "R2 status write ignored");
        rd(3'd7, d); check(d, 32'h0, "R2 unused address");

        // R6 remap source 23 to level 15, then to level 3
        wr(3'd5, 32'hFDDCCBBB);
        drive_src(24'h800000);
        check({16'h0, irq_level}, 32'h8000, "R6 remap to level 15");
        wr(3'd5, 32'h3DDCCBBB);
        @(posedge clk); @(negedge clk);
        check({16'h0, irq_level}, 32'h0, "R6 field value 3 reaches nothing");
        rd(3'd5, d); check(d, 32'h3DDCCBBB, "R6 assign readback");
        drive_src(24'h0);

        // R7 wakeup
        wr(3'd0, 32'h0);
        wr(3'd2, 32'h00000020);
        @(negedge clk); core_idle = 1'b1;
        drive_src(24'h000020);
        check({31'h0, wake_req}, 32'h1, "R7 wake with mask clear");
        check({16'h0, irq_level}, 32'h0, "R3 masked source silent");
        @(negedge clk); core_idle = 1'b0;
        @(posedge clk); @(negedge clk);
        check({31'h0, wake_req}, 32'h0, "R7 no wake when busy");
        @(negedge clk); core_idle = 1'b1;
        drive_src(24'h000010);
        check({31'h0, wake_req}, 32'h0, "R7 disabled source no wake");
        @(negedge clk); core_idle = 1'b0;

        // R8 re-arm gap on level 7
        wr(3'd0, 32'h00FFFFFF);
        drive_src(24'h000001);
        check({31'h0, irq_level[7]}, 32'h1, "R8 level 7 active before ack");
        core_gp_pend = 9'h001;
        @(posedge clk); @(negedge clk);
        check({31'h0, irq_level[7]}, 32'h0, "R8 gap cycle");
        @(posedge clk); @(negedge clk);
        check({31'h0, irq_level[7]}, 32'h1, "R8 line returns");
        @(posedge clk); @(negedge clk);
        check({31'h0, irq_level[7]}, 32'h1, "R8 held pend no second gap");
        core_gp_pend = 9'h0;

        finish_run();
    end
endmodule